// File: doc/BRIEF.md
# Clock Output Divider and Enable Stage

This stage sits between a clock synthesizer and the output pads. It turns a fast synthesized clock into a primary output by dividing it by a power of two, R. It also produces a secondary output that divides the primary by a second power of two, X. The primary output can instead be switched to carry a reference clock.

Each output has a drive-enable signal for a tri-state pad. The enable is asserted only when both the shared enable pin and that output's own configuration bit allow it.

The codes and select bits come from a configuration loader and are taken in on a one-cycle commit strobe. The strobe is synchronous to the fast clock. A new divide setting takes effect only at a divider period boundary, so no output pulse is cut short. The reference handover uses a two-sided enable handshake, so neither source is ever partially passed.

Top module: `clkout_stage`

## Requirements
- R1: `clk_main` (reference select 0) is the fast clock divided by R, where `r_code` 0,1,2,3 gives R = 1,2,4,8. For R of 2 or more, each period starts on a rising fast-clock edge, is high for R/2 fast cycles, then low for R/2. For R = 1, the output follows the fast clock.
- R2: `clk_aux` is the divided primary path divided by X, where `x_code` 0,1,2,3 gives X = 1,2,4,8. For X of 2 or more, it is high for the first X/2 primary periods of each X-period group. For X = 1, it equals the divided primary path. The reference select never affects it.
- R3: Codes taken at a commit are applied to R only at the first R-period boundary after the commit. They are applied to X only at the first boundary where an X group ends.
- R4: After a commit with `ref_sel` = 1 and a handover settling time, `clk_main` follows `ref_clk`. After a commit with `ref_sel` = 0, it returns to the divided path. The two source enables are never on together.
- R5: `clk_main_oe` equals `oe_pin` AND the primary enable bit. `clk_aux_oe` equals `oe_pin` AND the secondary enable bit. Both bits are taken at commit.
- R6: With `oe_pin` low, both drive enables are low.
- R7: Changes on `r_code`, `x_code`, `ref_sel` or the enable bits have no effect without `commit`.
- R8: While `rst_n` is low, both clocks are low and all counters are cleared. The codes are `DEF_R_CODE` and `DEF_X_CODE`, both enable bits are 1, and the select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast synthesized clock |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | One-cycle strobe that takes in the configuration |
| r_code | input | SEL_W | Primary divide code |
| x_code | input | SEL_W | Secondary divide code |
| ref_sel | input | 1 | 1 puts the reference on the primary output |
| main_en_bit | input | 1 | Primary output enable bit |
| aux_en_bit | input | 1 | Secondary output enable bit |
| oe_pin | input | 1 | Shared active-high output enable |
| clk_main | output | 1 | Primary clock |
| clk_main_oe | output | 1 | Primary pad drive enable |
| clk_aux | output | 1 | Secondary clock |
| clk_aux_oe | output | 1 | Secondary pad drive enable |

## Verification
The bench builds the block with SEL_W of 2, a reset R code of 1 and a reset X code of 2. With those values all four codes of each divider are reachable, including the pass-through setting R = 1 and the deepest setting of 8. Commits are issued at many offsets inside a running period, so the deferred application of new codes is exercised at several phases. A reference clock that is not related to the fast clock exercises the handover in both directions.

// File: rtl/clkout_stage.sv
`timescale 1ns/1ps
module clkout_stage #(
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] DEF_R_CODE = 1,
  parameter logic [SEL_W-1:0] DEF_X_CODE = 2
) (
  input  logic             vco_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SEL_W-1:0] r_code,
  input  logic [SEL_W-1:0] x_code,
  input  logic             ref_sel,
  input  logic             main_en_bit,
  input  logic             aux_en_bit,
  input  logic             oe_pin,
  output logic             clk_main,
  output logic             clk_main_oe,
  output logic             clk_aux,
  output logic             clk_aux_oe
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  function automatic logic [CNT_W:0] span(input logic [SEL_W-1:0] c);
    return {{CNT_W{1'b0}}, 1'b1} << c;
  endfunction

  function automatic logic [CNT_W-1:0] lastc(input logic [SEL_W-1:0] c);
    logic [CNT_W:0] t;
    t = span(c) - (CNT_W+1)'(1);
    return t[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W:0] half(input logic [SEL_W-1:0] c);
    return span(c) >> 1;
  endfunction

  logic [SEL_W-1:0] r_pend, x_pend, r_act, x_act, r_nxt, x_nxt;
  logic [CNT_W-1:0] rcnt, xcnt, rcnt_nxt, xcnt_nxt;
  logic             sel_q, men_q, aen_q, run;
  logic             div_q, aux_q, rterm, xterm, r1, x1;
  logic             main_raw, aux_raw;
  logic             v_meta, v_en, r_meta, r_en;

  assign rterm    = (rcnt == lastc(r_act));
  assign xterm    = rterm && (xcnt == lastc(x_act));
  assign r_nxt    = rterm ? r_pend : r_act;
  assign x_nxt    = xterm ? x_pend : x_act;
  assign rcnt_nxt = rterm ? '0 : rcnt + CNT_W'(1);
  assign xcnt_nxt = xterm ? '0 : (rterm ? xcnt + CNT_W'(1) : xcnt);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_pend <= DEF_R_CODE;
      x_pend <= DEF_X_CODE;
      r_act  <= DEF_R_CODE;
      x_act  <= DEF_X_CODE;
      rcnt   <= '0;
      xcnt   <= '0;
      div_q  <= 1'b0;
      aux_q  <= 1'b0;
      sel_q  <= 1'b0;
      men_q  <= 1'b1;
      aen_q  <= 1'b1;
      run    <= 1'b0;
    end else begin
      run   <= 1'b1;
      r_act <= r_nxt;
      x_act <= x_nxt;
      rcnt  <= rcnt_nxt;
      xcnt  <= xcnt_nxt;
      div_q <= ({1'b0, rcnt_nxt} < half(r_nxt));
      if (rterm) aux_q <= ({1'b0, xcnt_nxt} < half(x_nxt));
      if (commit) begin
        r_pend <= r_code;
        x_pend <= x_code;
        sel_q  <= ref_sel;
        men_q  <= main_en_bit;
        aen_q  <= aux_en_bit;
      end
    end
  end

  assign r1       = (r_act == '0);
  assign x1       = (x_act == '0);
  assign main_raw = r1 ? (vco_clk & run) : div_q;
  assign aux_raw  = x1 ? main_raw : aux_q;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) v_meta <= 1'b0;
    else        v_meta <= !sel_q && !r_en;
  end

  always_ff @(negedge vco_clk or negedge rst_n) begin
    if (!rst_n)              v_en <= 1'b0;
    else if (r1 || !div_q)   v_en <= v_meta;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) r_meta <= 1'b0;
    else        r_meta <= sel_q && !v_en;
  end

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) r_en <= 1'b0;
    else        r_en <= r_meta;
  end

  assign clk_main    = (main_raw & v_en) | (ref_clk & r_en);
  assign clk_aux     = aux_raw;
  assign clk_main_oe = oe_pin & men_q;
  assign clk_aux_oe  = oe_pin & aen_q;
endmodule

module clkout_stage_chk #(
  parameter int SEL_W = 2
) (
  input logic                       vco_clk,
  input logic                       rst_n,
  input logic                       commit,
  input logic                       main_en_bit,
  input logic                       oe_pin,
  input logic                       clk_main,
  input logic                       clk_aux,
  input logic                       clk_main_oe,
  input logic                       clk_aux_oe,
  input logic [SEL_W-1:0]           r_act,
  input logic [SEL_W-1:0]           x_act,
  input logic [SEL_W-1:0]           r_pend,
  input logic [SEL_W-1:0]           x_pend,
  input logic [(1<<SEL_W)-2:0]      rcnt,
  input logic [(1<<SEL_W)-2:0]      xcnt,
  input logic                       div_q,
  input logic                       v_en,
  input logic                       r_en
);
  AST_RESET_QUIET: assert property (@(posedge vco_clk)
    !rst_n |-> !clk_main && !clk_aux); // R8

  AST_DIV_START: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $rose(div_q) |-> rcnt == '0); // R1

  AST_R_AT_TERMINAL: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(r_act) |-> int'($past(rcnt)) == (1 << $past(r_act)) - 1); // R3

  AST_X_AT_TERMINAL: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(x_act) |-> (int'($past(rcnt)) == (1 << $past(r_act)) - 1) &&
                        (int'($past(xcnt)) == (1 << $past(x_act)) - 1)); // R3

  AST_MUX_EXCLUSIVE: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !(v_en && r_en)); // R4

  AST_OE_OFF_AFTER_COMMIT: assert property (@(posedge vco_clk) disable iff (!rst_n)
    commit && !main_en_bit |=> !clk_main_oe); // R5

  AST_PIN_LOW_QUIET: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $fell(oe_pin) |-> !clk_main_oe && !clk_aux_oe); // R6

  AST_NO_COMMIT_HOLD: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !commit |=> $stable(r_pend) && $stable(x_pend)); // R7
endmodule

bind clkout_stage clkout_stage_chk #(.SEL_W(SEL_W)) u_chk (
  .vco_clk(vco_clk), .rst_n(rst_n), .commit(commit), .main_en_bit(main_en_bit),
  .oe_pin(oe_pin), .clk_main(clk_main), .clk_aux(clk_aux),
  .clk_main_oe(clk_main_oe), .clk_aux_oe(clk_aux_oe),
  .r_act(r_act), .x_act(x_act), .r_pend(r_pend), .x_pend(x_pend),
  .rcnt(rcnt), .xcnt(xcnt), .div_q(div_q), .v_en(v_en), .r_en(r_en)
);

// File: tb/clkout_stage_test.sv
`timescale 1ns/1ps
module clkout_stage_test;
  localparam int SW = 2;
  localparam logic [1:0] DR = 2'd1;
  localparam logic [1:0] DX = 2'd2;

  logic vco_clk = 0, ref_clk = 0, rst_n = 0, commit = 0;
  logic ref_sel = 0, men = 1, aen = 1, oe_pin = 1;
  logic [1:0] r_code = DR, x_code = DX;
  logic clk_main, clk_main_oe, clk_aux, clk_aux_oe;

  clkout_stage #(.SEL_W(SW), .DEF_R_CODE(DR), .DEF_X_CODE(DX)) uut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .commit(commit),
    .r_code(r_code), .x_code(x_code), .ref_sel(ref_sel),
    .main_en_bit(men), .aux_en_bit(aen), .oe_pin(oe_pin),
    .clk_main(clk_main), .clk_main_oe(clk_main_oe),
    .clk_aux(clk_aux), .clk_aux_oe(clk_aux_oe));

  always #2.5 vco_clk = ~vco_clk;
  always #8 ref_clk = ~ref_clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R8";

  int m_ra, m_rp, m_rc, m_xa, m_xp, m_xc, m_skip;
  bit m_div, m_aux, m_sel, m_men, m_aen;

  always @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ra = DR; m_rp = DR; m_rc = 0; m_xa = DX; m_xp = DX; m_xc = 0;
      m_div = 0; m_aux = 0; m_sel = 0; m_men = 1; m_aen = 1; m_skip = 4;
    end else begin
      if (m_rc == (1 << m_ra) - 1) begin
        if (m_xc == (1 << m_xa) - 1) begin m_xc = 0; m_xa = m_xp; end
        else m_xc++;
        m_aux = (m_xc < (1 << m_xa) / 2);
        m_rc = 0; m_ra = m_rp;
      end else m_rc++;
      m_div = (m_rc < (1 << m_ra) / 2);
      if (commit) begin
        m_rp = r_code; m_xp = x_code;
        if (ref_sel != m_sel) m_skip = 40;
        m_sel = ref_sel; m_men = men; m_aen = aen;
      end
      if (m_skip > 0) m_skip--;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0b expected %0b at %0t", req, tag, what, act, exp, $time);
    end
  endtask

  task automatic sample(input bit hi);
    logic raw;
    if (!rst_n) begin
      check("R8", clk_main, 1'b0, "clk_main in reset");
      check("R8", clk_aux, 1'b0, "clk_aux in reset");
    end else begin
      raw = (m_ra == 0) ? hi : m_div;
      check("R2", clk_aux, (m_xa == 0) ? raw : m_aux, "clk_aux");
      if (m_skip == 0)
        check(m_sel ? "R4" : "R1", clk_main, m_sel ? ref_clk : raw, "clk_main");
    end
    check(oe_pin ? "R5" : "R6", clk_main_oe, oe_pin & m_men, "clk_main_oe");
    check(oe_pin ? "R5" : "R6", clk_aux_oe, oe_pin & m_aen, "clk_aux_oe");
  endtask

  initial forever begin
    @(posedge vco_clk); #1.25; sample(1'b1);
    @(negedge vco_clk); #1.25; sample(1'b0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge vco_clk);
  endtask

  task automatic load(input logic [1:0] rc, input logic [1:0] xc, input bit s, input bit me, input bit ae);
    @(negedge vco_clk);
    r_code = rc; x_code = xc; ref_sel = s; men = me; aen = ae; commit = 1;
    @(negedge vco_clk);
    commit = 0;
  endtask

  initial begin
    cyc(6);
    rst_n = 1;
    tag = "R1"; cyc(40);
    tag = "R3"; load(2'd3, 2'd1, 0, 1, 1); cyc(80);
    tag = "R2"; load(2'd0, 2'd3, 0, 1, 1); cyc(100);
    tag = "R7"; r_code = 2'd2; x_code = 2'd0; ref_sel = 1; men = 0; aen = 0; cyc(60);
    tag = "R3"; load(2'd2, 2'd0, 0, 1, 1); cyc(60);
    tag = "R5"; load(2'd2, 2'd0, 0, 0, 1); cyc(10);
    load(2'd2, 2'd0, 0, 1, 0); cyc(10);
    tag = "R6"; oe_pin = 0; cyc(10); oe_pin = 1;
    load(2'd2, 2'd0, 0, 1, 1); cyc(10);
    tag = "R4"; load(2'd2, 2'd1, 1, 1, 1); cyc(120);
    load(2'd1, 2'd1, 0, 1, 1); cyc(80);
    tag = "R3";
    for (int i = 0; i < 8; i++) begin
      load(2'(i % 4), 2'((i + 1) % 4), 0, 1, 1);
      cyc(i + 1);
    end
    cyc(80);
    tag = "R8"; rst_n = 0; cyc(3); rst_n = 1; cyc(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge vco_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule